// File: doc/BRIEF.md
# Sector ECC Verdict and Single-Bit Repair

This block judges the health of one sector after it has been read back from flash. It takes the raw 32-bit parity word produced by a parity engine during the read, folds it into a 24-bit code, and compares that code with the 24-bit code that was saved next to the sector when the sector was written. From the XOR of the two codes it reaches one of four verdicts. The sector is clean, or one data bit is wrong and can be repaired, or the saved code itself has one bad bit while the data is fine, or the damage is beyond repair.

The 24-bit code holds twelve parity bits and their twelve complements. A single flipped data bit therefore produces a difference whose two 12-bit halves are exact complements of each other. The upper half then gives the byte offset and the bit index of the bad bit. The code is kept inverted, so a sector that was erased to all ones, whose parity fields read as zero, matches a saved code of all ones.

When repair mode is requested and the verdict is a repairable data bit, the block runs a read-modify-write cycle on a small sector RAM port. It reads the byte at the reported offset, flips the reported bit, and writes the byte back.

Top module: `hamm_sector_fix`

## Requirements
- R1: `calc_code` is the bitwise inverse of the 24-bit value whose bits 11:0 are `calc_raw[11:0]` and whose bits 23:12 are `calc_raw[27:16]`. Raw bits 31:28 and 15:12 have no effect on it.
- R2: `stored_code` carries the saved code as three bytes, with the first byte in bits 7:0 and the third in bits 23:16. The difference is `calc_code ^ stored_code`.
- R3: A `start` taken while `busy` is low gives a one-cycle `done` pulse in the next cycle. `status` holds the verdict until the next accepted start: 0 clean, 1 data bit repairable, 2 saved code damaged, 3 uncorrectable. After reset `done`, `busy` and `status` are 0.
- R4: A zero difference gives status 0 and an `err_mask` of 0.
- R5: When the XOR of the difference's upper and lower 12 bits is all ones, and difference bits 23:15 are below SECTOR_BYTES, the status is 1. `err_offset` is then difference bits 23:15 and `err_mask` is one-hot at the index given by difference bits 14:12.
- R6: A complementary difference whose offset is SECTOR_BYTES or more gives status 3 and starts no RAM access, even in repair mode.
- R7: A difference with exactly one bit set gives status 2 and an `err_mask` of 0, and starts no RAM access, even in repair mode.
- R8: Any other nonzero difference gives status 3 and an `err_mask` of 0.
- R9: With `fix_en` high and status 1, `ram_rd` is high at `err_offset` in the `done` cycle. In the next cycle `ram_wr` is high at the same address with `ram_rdata ^ err_mask`. `fix_done` pulses one cycle later. No other byte changes.
- R10: A `start` taken while `busy` is high is ignored. It produces no `done` pulse and leaves the repair in progress intact.
- R11: An erased sector, with parity fields of zero and a saved code of 0xFFFFFF, gives status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a compare |
| fix_en | input | 1 | Repair the data bit in sector RAM on a repairable verdict |
| calc_raw | input | 32 | Raw parity word computed during the read |
| stored_code | input | 24 | Saved code, first byte in bits 7:0 |
| calc_code | output | 24 | Folded and inverted code from `calc_raw` |
| done | output | 1 | One-cycle pulse when the verdict is valid |
| status | output | 2 | Verdict code |
| err_offset | output | 9 | Byte offset of the bad bit |
| err_mask | output | 8 | One-hot mask of the bad bit |
| busy | output | 1 | Repair cycle in progress |
| ram_rd | output | 1 | Sector RAM read strobe (data one cycle later) |
| ram_wr | output | 1 | Sector RAM write strobe |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_wdata | output | 8 | Sector RAM write data |
| ram_rdata | input | 8 | Sector RAM read data |
| fix_done | output | 1 | Pulse after the repaired byte is written |

## Verification
The case that is hardest to reach from the ports is a difference that has the complementary pattern but points past the end of the sector. With 512-byte sectors and a 9-bit offset field, no such difference exists. The bench therefore builds the block for a 320-byte sector and creates differences at offsets 319, 320 and 511, each by XORing a chosen complementary pattern into the saved code. A second `start` is issued in the cycle right after a repair begins, to show that it is dropped while the read-modify-write finishes.

// File: rtl/ecc_fix_pkg.sv
// Shared types for the sector ECC verdict block.
// Assumes a two-bit verdict encoding that is visible at the top-level port.
package ecc_fix_pkg;

    typedef enum logic [1:0] {
        V_CLEAN    = 2'd0,
        V_DATA_FIX = 2'd1,
        V_CODE_FIX = 2'd2,
        V_UNCORR   = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } rmw_state_e;

endpackage

// File: rtl/ecc_code_pack.sv
// Folds the raw parity word into the stored code format.
// Each LANE_W-bit half of the raw word carries PAR_BITS parity bits at its
// bottom; the bits above them are reserved and dropped. The result is
// inverted so that all-zero parity (an erased sector) gives all ones.
module ecc_code_pack #(
    parameter int PAR_BITS = 12,
    parameter int LANE_W   = 16
) (
    input  logic [2*LANE_W-1:0]   raw_word,
    output logic [2*PAR_BITS-1:0] code
);
    localparam int RSV_W = LANE_W - PAR_BITS;

    // Reserved bits are dropped on purpose.
    logic [2*RSV_W-1:0] unused_rsvd;
    assign unused_rsvd = {raw_word[2*LANE_W-1:LANE_W+PAR_BITS],
                          raw_word[LANE_W-1:PAR_BITS]};

    // Per-bit fold and inversion of both parity lanes.
    for (genvar g = 0; g < PAR_BITS; g++) begin : g_bit
        assign code[g]            = ~raw_word[g];
        assign code[PAR_BITS + g] = ~raw_word[LANE_W + g];
    end
endmodule

// File: rtl/ecc_syndrome_judge.sv
// Combinational verdict on the XOR of the calculated and stored codes.
// Assumes the upper half of the code is the complement of the lower half
// for a clean single data-bit error, with the byte offset above a 3-bit
// bit index in the upper half.
module ecc_syndrome_judge
    import ecc_fix_pkg::*;
#(
    parameter int PAR_BITS     = 12,
    parameter int SECTOR_BYTES = 512
) (
    input  logic [2*PAR_BITS-1:0] calc_code,
    input  logic [2*PAR_BITS-1:0] stored_code,
    output verdict_e              verdict,
    output logic [PAR_BITS-4:0]   offset,
    output logic [7:0]            mask
);
    localparam int CODE_W = 2 * PAR_BITS;

    logic [CODE_W-1:0]   diff;
    logic [PAR_BITS-1:0] halves_x;
    logic                pair_ok;
    logic                one_hot;
    logic                in_range;
    logic [2:0]          bit_idx;

    // Difference and its structural features.
    always_comb begin
        diff     = calc_code ^ stored_code;
        halves_x = diff[CODE_W-1:PAR_BITS] ^ diff[PAR_BITS-1:0];
        pair_ok  = &halves_x;
        one_hot  = (diff != '0) && ((diff & (diff - CODE_W'(1))) == '0);
        offset   = diff[CODE_W-1:PAR_BITS+3];
        bit_idx  = diff[PAR_BITS+2:PAR_BITS];
        in_range = 32'(offset) < 32'(SECTOR_BYTES);
    end

    // Verdict priority: clean, complementary pattern, lone flipped bit, rest.
    always_comb begin
        mask = 8'h00;
        if (diff == '0) begin
            verdict = V_CLEAN;
        end else if (pair_ok) begin
            if (in_range) begin
                verdict = V_DATA_FIX;
                mask    = 8'h01 << bit_idx;
            end else begin
                verdict = V_UNCORR;
            end
        end else if (one_hot) begin
            verdict = V_CODE_FIX;
        end else begin
            verdict = V_UNCORR;
        end
    end
endmodule

// File: rtl/ecc_rmw_seq.sv
// Read-modify-write sequencer for a one-byte repair in sector RAM.
// Assumes the RAM returns read data one cycle after the read strobe.
// The sequence takes one read cycle and one write cycle, and fix_done
// follows the write by one cycle.
module ecc_rmw_seq
    import ecc_fix_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        mask_in,
    input  logic [7:0]        ram_rdata,
    output logic              busy,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              fix_done
);
    rmw_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        mask_q;

    // State walk IDLE -> RD -> WR -> IDLE, with the target captured on go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            mask_q   <= '0;
            fix_done <= 1'b0;
        end else begin
            fix_done <= (state == S_WR);
            case (state)
                S_IDLE: if (go) begin
                    addr_q <= addr_in;
                    mask_q <= mask_in;
                    state  <= S_RD;
                end
                S_RD:    state <= S_WR;
                S_WR:    state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // RAM strobes and the flipped write byte.
    always_comb begin
        busy      = (state != S_IDLE);
        ram_rd    = (state == S_RD);
        ram_wr    = (state == S_WR);
        ram_addr  = addr_q;
        ram_wdata = ram_rdata ^ mask_q;
    end
endmodule

// File: rtl/hamm_sector_fix.sv
// Sector ECC verdict block: folds the raw parity word, compares it with
// the stored code, registers the verdict with a one-cycle done pulse, and
// can repair a single data bit in sector RAM.
// Assumes start is ignored while a repair is running.
module hamm_sector_fix
    import ecc_fix_pkg::*;
#(
    parameter int PAR_BITS     = 12,
    parameter int LANE_W       = 16,
    parameter int SECTOR_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  fix_en,
    input  logic [2*LANE_W-1:0]   calc_raw,
    input  logic [2*PAR_BITS-1:0] stored_code,
    output logic [2*PAR_BITS-1:0] calc_code,
    output logic                  done,
    output logic [1:0]            status,
    output logic [PAR_BITS-4:0]   err_offset,
    output logic [7:0]            err_mask,
    output logic                  busy,
    output logic                  ram_rd,
    output logic                  ram_wr,
    output logic [PAR_BITS-4:0]   ram_addr,
    output logic [7:0]            ram_wdata,
    input  logic [7:0]            ram_rdata,
    output logic                  fix_done
);
    localparam int OFF_W = PAR_BITS - 3;

    verdict_e         verdict;
    logic [OFF_W-1:0] judge_off;
    logic [7:0]       judge_mask;
    logic             accept;
    logic             go_fix;
    verdict_e         status_q;
    logic [OFF_W-1:0] off_q;
    logic [7:0]       mask_q;
    logic             done_q;

    ecc_code_pack #(.PAR_BITS(PAR_BITS), .LANE_W(LANE_W)) u_pack (
        .raw_word (calc_raw),
        .code     (calc_code)
    );

    ecc_syndrome_judge #(.PAR_BITS(PAR_BITS), .SECTOR_BYTES(SECTOR_BYTES)) u_judge (
        .calc_code   (calc_code),
        .stored_code (stored_code),
        .verdict     (verdict),
        .offset      (judge_off),
        .mask        (judge_mask)
    );

    // Start acceptance and the repair trigger.
    always_comb begin
        accept = start && !busy;
        go_fix = accept && fix_en && (verdict == V_DATA_FIX);
    end

    // Verdict registers, refreshed on each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            status_q <= V_CLEAN;
            off_q    <= '0;
            mask_q   <= '0;
        end else begin
            done_q <= accept;
            if (accept) begin
                status_q <= verdict;
                off_q    <= judge_off;
                mask_q   <= judge_mask;
            end
        end
    end

    ecc_rmw_seq #(.ADDR_W(OFF_W)) u_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_fix),
        .addr_in   (judge_off),
        .mask_in   (judge_mask),
        .ram_rdata (ram_rdata),
        .busy      (busy),
        .ram_rd    (ram_rd),
        .ram_wr    (ram_wr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .fix_done  (fix_done)
    );

    // Output drive from the verdict registers.
    always_comb begin
        done       = done_q;
        status     = status_q;
        err_offset = off_q;
        err_mask   = mask_q;
    end
endmodule

// File: rtl/hamm_sector_fix_chk.sv
// Property checker for hamm_sector_fix, attached with bind below.
// Assumes the same synchronous active-low reset as the design.
module hamm_sector_fix_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [1:0]        status,
    input logic [7:0]        err_mask,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_rdata,
    input logic [7:0]        ram_wdata,
    input logic              fix_done
);
    assert_done_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> done);

    assert_done_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start && !busy));

    assert_clean_no_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> (err_mask == 8'h00));

    assert_fix_mask_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> ($countones(err_mask) == 1));

    assert_no_access_unless_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd1) |-> !ram_rd);

    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ($past(ram_rd) && $stable(ram_addr)));

    assert_write_flips_one_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> ($countones(ram_wdata ^ ram_rdata) == 1));

    assert_fix_done_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fix_done |-> $past(ram_wr));

    assert_busy_start_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !done);
endmodule

bind hamm_sector_fix hamm_sector_fix_chk #(.ADDR_W(PAR_BITS - 3)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .err_mask  (err_mask),
    .ram_rd    (ram_rd),
    .ram_wr    (ram_wr),
    .ram_addr  (ram_addr),
    .ram_rdata (ram_rdata),
    .ram_wdata (ram_wdata),
    .fix_done  (fix_done)
);

// File: tb/sim_hamm_sector_fix.sv
module sim_hamm_sector_fix;
    localparam int SECT = 320;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fix_en = 1'b0;
    logic [31:0] calc_raw = '0;
    logic [23:0] stored_code = '0;
    logic [23:0] calc_code;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  err_offset;
    logic [7:0]  err_mask;
    logic        busy;
    logic        ram_rd;
    logic        ram_wr;
    logic [8:0]  ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic        fix_done;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int fd_cnt = 0;
    int spurious = 0;

    logic [18:0] exp_q [$];
    string       tag_q [$];
    logic [7:0]  mem [0:511];

    always #5 clk = ~clk;

    hamm_sector_fix #(.SECTOR_BYTES(SECT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
        .calc_raw(calc_raw), .stored_code(stored_code), .calc_code(calc_code),
        .done(done), .status(status), .err_offset(err_offset), .err_mask(err_mask),
        .busy(busy), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .fix_done(fix_done)
    );

    // Sector RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (ram_wr) mem[ram_addr] <= ram_wdata;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] pack_m(input logic [31:0] r);
        logic [23:0] c;
        for (int i = 0; i < 12; i++) begin
            c[i]      = ~r[i];
            c[i + 12] = ~r[i + 16];
        end
        return c;
    endfunction

    function automatic logic [1:0] judge_m(input logic [23:0] d);
        int n = 0;
        bit comp = 1'b1;
        for (int i = 0; i < 24; i++) n += int'(d[i]);
        for (int i = 0; i < 12; i++) if (d[i] == d[i + 12]) comp = 1'b0;
        if (n == 0) return 2'd0;
        if (comp) return ((int'(d) / 32768) < SECT) ? 2'd1 : 2'd3;
        if (n == 1) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [23:0] corr(input int off, input int b);
        logic [11:0] h;
        h = {off[8:0], b[2:0]};
        return {h, ~h};
    endfunction

    // Driver: presents one compare and queues the expected verdict.
    task automatic run(input logic [31:0] raw, input logic [23:0] d, input logic fx,
                       input bit push, input string tag);
        logic [1:0] st;
        logic [8:0] off;
        logic [7:0] m;
        @(negedge clk);
        calc_raw    = raw;
        stored_code = pack_m(raw) ^ d;
        fix_en      = fx;
        start       = 1'b1;
        st  = judge_m(d);
        off = (st == 2'd1) ? d[23:15] : 9'd0;
        m   = (st == 2'd1) ? (8'h01 << d[14:12]) : 8'h00;
        if (push) begin
            exp_q.push_back({st, off, m});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        start  = 1'b0;
        fix_en = 1'b0;
    endtask

    // Monitor: pops the scoreboard on each done pulse and counts RAM traffic.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ram_rd) rd_cnt++;
            if (ram_wr) wr_cnt++;
            if (fix_done) fd_cnt++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    spurious++;
                    check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    logic [18:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({status, (status == 2'd1) ? err_offset : 9'd0, err_mask} == e,
                          t, {13'd0, status, (status == 2'd1) ? err_offset : 9'd0, err_mask},
                          {13'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int r0, w0;
        logic [7:0] save37, save36, save38, save100;
        for (int i = 0; i < 512; i++) mem[i] = 8'((i * 7) + 3);
        repeat (3) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0 && status == 2'd0, "R3 reset state",
              {29'd0, done, status}, 32'd0);
        check(ram_rd == 1'b0 && ram_wr == 1'b0 && fix_done == 1'b0, "R9 reset strobes",
              {29'd0, ram_rd, ram_wr, fix_done}, 32'd0);
        rst_n = 1'b1;

        // R1: folding and inversion, reserved bits ignored.
        calc_raw = 32'hA5A5_5A5A; #1;
        check(calc_code == pack_m(32'hA5A5_5A5A), "R1 pack", calc_code, pack_m(32'hA5A5_5A5A));
        calc_raw = 32'hF000_F000; #1;
        check(calc_code == 24'hFFFFFF, "R1 reserved ignored", calc_code, 24'hFFFFFF);
        calc_raw = 32'h0123_4567; #1;
        check(calc_code == 24'hEDCA98, "R1 fixed value", calc_code, 24'hEDCA98);

        run(32'h0000_0000, 24'h0, 1'b0, 1'b1, "R11 erased sector");
        run(32'h1357_9BDF, 24'h0, 1'b0, 1'b1, "R4 clean");
        run(32'h0ACE_0246, corr(5, 3), 1'b0, 1'b1, "R5 offset 5 bit 3");
        run(32'h7777_1111, corr(0, 0), 1'b0, 1'b1, "R5 offset 0 bit 0");
        run(32'h0FFF_0FFF, corr(319, 7), 1'b0, 1'b1, "R5 last byte in range");
        run(32'h0ABC_0DEF, corr(200, 4), 1'b0, 1'b1, "R2 upper byte offset");
        run(32'h0123_0456, corr(320, 0), 1'b0, 1'b1, "R6 first byte past sector");
        run(32'h0321_0654, corr(511, 5), 1'b0, 1'b1, "R6 top offset");
        run(32'h0AAA_0555, 24'h020000, 1'b0, 1'b1, "R7 upper code bit");
        run(32'h0AAA_0555, 24'h000001, 1'b0, 1'b1, "R7 lowest code bit");
        run(32'h0BBB_0CCC, 24'h000003, 1'b0, 1'b1, "R8 two bits");
        run(32'h0BBB_0CCC, 24'h00F00F, 1'b0, 1'b1, "R8 mixed pattern");

        // R9: repair of one bit.
        save37 = mem[37]; save36 = mem[36]; save38 = mem[38];
        r0 = fd_cnt;
        run(32'h0246_0135, corr(37, 6), 1'b1, 1'b1, "R9 repair verdict");
        repeat (4) @(negedge clk);
        check(mem[37] == (save37 ^ 8'h40), "R9 byte repaired", mem[37], save37 ^ 8'h40);
        check(mem[36] == save36 && mem[38] == save38, "R9 neighbours intact",
              {mem[36], mem[38]}, {save36, save38});
        check(fd_cnt == r0 + 1, "R9 fix_done pulse", fd_cnt, r0 + 1);

        // R7 and R6 in repair mode: no RAM traffic.
        r0 = rd_cnt; w0 = wr_cnt;
        run(32'h0246_0135, 24'h000010, 1'b1, 1'b1, "R7 repair mode code bit");
        run(32'h0246_0135, corr(400, 2), 1'b1, 1'b1, "R6 repair mode out of range");
        repeat (4) @(negedge clk);
        check(rd_cnt == r0 && wr_cnt == w0, "R7 R6 no RAM access",
              rd_cnt + wr_cnt, r0 + w0);

        // R10: start during the repair is dropped.
        save100 = mem[100];
        r0 = spurious;
        run(32'h0111_0222, corr(100, 1), 1'b1, 1'b1, "R10 repair verdict");
        calc_raw    = 32'h0;
        stored_code = 24'h123456;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check(spurious == r0 && exp_q.size() == 0, "R10 no extra done",
              spurious - r0, 32'd0);
        check(mem[100] == (save100 ^ 8'h02), "R10 repair intact", mem[100], save100 ^ 8'h02);
        check(status == 2'd1, "R3 status held", status, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule